// File: doc/BRIEF.md
# Transmit Frame Descriptor Parser

This block accepts one 128-byte transmit frame descriptor as a stream of 32 dwords on a valid/ready input. The first dword is the control word. It gives the number of transmit buffers in use and the number of padding dwords that bring the frame up to a 16-byte boundary. The next 30 dwords hold up to ten packed pairs of buffer descriptors, and the final dword is not used. Each buffer has a 36-bit address and a 12-bit byte length. Some of those bit fields are split across dword boundaries.

Once the whole descriptor is held, the block spends one cycle judging it. A descriptor is rejected for any of these reasons: a buffer count that is zero or too large, a buffer address that is not on a dword boundary, a buffer that is too long, or a frame total that is too long. A rejected descriptor raises a one-cycle error pulse and produces no records. An accepted descriptor produces one (address, length) record per buffer on a valid/ready output, in order. The last record is tagged. The frame's total byte length and its pad count are presented beside every record, ready for a gather DMA engine downstream.

Top module: `tfd_parser`

## Requirements
- R1: The buffer count is control dword bits [28:24], and the pad count is control dword bits [31:30]. The pad count appears on `frm_pad` with every record of the descriptor.
- R2: Pair p (p = 0..9) occupies descriptor dwords 1+3p, 2+3p and 3+3p, with field positions as follows. For its first buffer, address [31:0] is dword 1+3p, address [35:32] is dword 2+3p bits [3:0], and the length is dword 2+3p bits [15:4]. For its second buffer, address [15:0] is dword 2+3p bits [31:16], address [35:16] is dword 3+3p bits [19:0], and the length is dword 3+3p bits [31:20]. Each record carries exactly these values.
- R3: An accepted descriptor with count N yields exactly N records, in buffer order 0..N-1 (within a pair, the first buffer comes before the second). `rec_last` is high on record N-1 only.
- R4: A buffer count of 0 or greater than 20 rejects the descriptor. `desc_err` pulses and no record is emitted. The block then returns to collecting.
- R5: A buffer in use whose address bits [1:0] are not zero rejects the descriptor. Fields of buffers at index N or above are ignored.
- R6: A buffer in use whose length exceeds 4092 bytes rejects the descriptor. A length of exactly 4092 is accepted.
- R7: `frm_len` equals the sum of the lengths of the buffers in use. A sum above 8192 rejects the descriptor, and a sum of exactly 8192 is accepted.
- R8: `in_ready` is high while dwords are being collected. In the cycle after the 32nd dword is accepted, `in_ready` and `rec_valid` are low and `desc_err` shows the verdict. Records start in the following cycle, and `in_ready` stays low until the last record is taken.
- R9: While `rec_valid` is high and `rec_ready` is low, the record fields hold steady.
- R10: After reset, `in_ready` is high and `rec_valid` and `desc_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor dword valid |
| in_ready | output | 1 | Block can take a descriptor dword |
| in_data | input | 32 | Descriptor dword, control dword first |
| rec_valid | output | 1 | Buffer record valid |
| rec_ready | input | 1 | Downstream takes the record |
| rec_addr | output | 36 | Buffer byte address |
| rec_len | output | 12 | Buffer byte length |
| rec_last | output | 1 | Final record of the frame |
| frm_len | output | 14 | Total frame byte length |
| frm_pad | output | 2 | Padding dwords after the frame |
| desc_err | output | 1 | One-cycle pulse: descriptor rejected |

## Verification
The hardest case to reach is a frame that breaks only the total-length limit. That needs at least three buffers close to the per-buffer maximum, all of them properly aligned, and the limit must be probed one dword on either side of 8192. The stimulus builds such descriptors directly. It also fills every unused buffer slot with random, often misaligned or oversize, values, so that any leak from slots beyond the count shows up as a false rejection. Random gaps on the input and random back-pressure on the output shift every verdict and record relative to the handshakes, and a cycle-level model checks all of them.

// File: rtl/tfdp_pkg.sv
package tfdp_pkg;
  localparam int DWORD_W = 32;
  localparam int ADDR_W  = 36;
  localparam int LEN_W   = 12;
  localparam int NB_W    = 5;
  localparam int PAD_W   = 2;
  localparam int NB_LSB  = 24;
  localparam int PAD_LSB = 30;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } tbuf_t;

  // first buffer of a pair: address low word, then high nibble + length
  function automatic tbuf_t lead_buf(input logic [DWORD_W-1:0] wa,
                                     input logic [DWORD_W-1:0] wb);
    tbuf_t r;
    r.addr = {wb[3:0], wa};
    r.len  = wb[15:4];
    return r;
  endfunction

  // second buffer of a pair: address split over two dwords
  function automatic tbuf_t trail_buf(input logic [DWORD_W-1:0] wb,
                                      input logic [DWORD_W-1:0] wc);
    tbuf_t r;
    r.addr = {wc[19:0], wb[31:16]};
    r.len  = wc[31:20];
    return r;
  endfunction

  function automatic logic buf_broken(input tbuf_t b, input int max_len);
    return (b.addr[1:0] != 2'b00) || (b.len > LEN_W'(max_len));
  endfunction
endpackage

// File: rtl/tfdp_collect.sv
module tfdp_collect
  import tfdp_pkg::*;
#(
  parameter int DESC_DWORDS = 32,
  parameter int KEEP        = 31
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          in_valid,
  input  logic [DWORD_W-1:0]            in_data,
  output logic [KEEP-1:0][DWORD_W-1:0]  desc_q,
  output logic                          done
);
  localparam int CW = $clog2(DESC_DWORDS);

  logic [CW-1:0] cnt;
  logic          take;
  logic          at_end;

  assign take   = en && in_valid;
  assign at_end = (cnt == CW'(DESC_DWORDS - 1));
  assign done   = take && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (take) cnt <= at_end ? '0 : cnt + 1'b1;
  end

  for (genvar k = 0; k < KEEP; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         desc_q[k] <= '0;
      else if (take && cnt == CW'(k))     desc_q[k] <= in_data;
    end
  end
endmodule

// File: rtl/tfdp_rules.sv
module tfdp_rules
  import tfdp_pkg::*;
#(
  parameter int MAX_BUFS    = 20,
  parameter int MAX_BUF_LEN = 4092,
  parameter int MAX_FRAME   = 8192,
  parameter int KEEP        = 31,
  parameter int SUM_W       = 17
) (
  input  logic [KEEP-1:0][DWORD_W-1:0] desc,
  output tbuf_t [MAX_BUFS-1:0]         bufs,
  output logic [NB_W-1:0]              n_bufs,
  output logic [PAD_W-1:0]             pad,
  output logic [SUM_W-1:0]             total,
  output logic                         bad
);
  localparam int PAIRS = MAX_BUFS / 2;

  logic count_bad;
  logic shape_bad;
  logic size_bad;
  logic unused_bits;

  assign n_bufs      = desc[0][NB_LSB +: NB_W];
  assign pad         = desc[0][PAD_LSB +: PAD_W];
  assign unused_bits = ^{desc[0][NB_LSB-1:0], desc[0][PAD_LSB-1]};

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign bufs[2*p]   = lead_buf (desc[1+3*p], desc[2+3*p]);
    assign bufs[2*p+1] = trail_buf(desc[2+3*p], desc[3+3*p]);
  end

  always_comb begin
    total     = '0;
    shape_bad = 1'b0;
    for (int i = 0; i < MAX_BUFS; i++) begin
      if (i < int'(n_bufs)) begin
        total = total + SUM_W'(bufs[i].len);
        if (buf_broken(bufs[i], MAX_BUF_LEN)) shape_bad = 1'b1;
      end
    end
  end

  assign count_bad = (n_bufs == '0) || (int'(n_bufs) > MAX_BUFS);
  assign size_bad  = (total > SUM_W'(MAX_FRAME));
  assign bad       = count_bad || shape_bad || size_bad;
endmodule

// File: rtl/tfdp_emit.sv
module tfdp_emit
  import tfdp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done,
  input  logic            bad,
  input  logic [NB_W-1:0] n_bufs,
  input  logic            rec_ready,
  output logic            fill_en,
  output logic            judge,
  output logic            rec_valid,
  output logic [NB_W-1:0] idx,
  output logic            last
);
  typedef enum logic [1:0] {S_FILL, S_JUDGE, S_SEND} st_t;
  st_t st;

  assign fill_en   = (st == S_FILL);
  assign judge     = (st == S_JUDGE);
  assign rec_valid = (st == S_SEND);
  assign last      = (idx == n_bufs - NB_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_FILL;
      idx <= '0;
    end else begin
      case (st)
        S_FILL:  if (done) st <= S_JUDGE;
        S_JUDGE: begin
          idx <= '0;
          st  <= bad ? S_FILL : S_SEND;
        end
        S_SEND: if (rec_ready) begin
          if (last) st <= S_FILL;
          else      idx <= idx + 1'b1;
        end
        default: st <= S_FILL;
      endcase
    end
  end
endmodule

// File: rtl/tfd_parser.sv
module tfd_parser
  import tfdp_pkg::*;
#(
  parameter int DESC_DWORDS = 32,
  parameter int MAX_BUFS    = 20,
  parameter int MAX_BUF_LEN = 4092,
  parameter int MAX_FRAME   = 8192,
  parameter int FRM_W       = $clog2(MAX_FRAME + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_data,
  output logic               rec_valid,
  input  logic               rec_ready,
  output logic [35:0]        rec_addr,
  output logic [11:0]        rec_len,
  output logic               rec_last,
  output logic [FRM_W-1:0]   frm_len,
  output logic [1:0]         frm_pad,
  output logic               desc_err
);
  localparam int KEEP  = 1 + 3 * (MAX_BUFS / 2);
  localparam int SUM_W = $clog2(MAX_BUFS * MAX_BUF_LEN + 1);

  logic [KEEP-1:0][DWORD_W-1:0] desc_q;
  tbuf_t [MAX_BUFS-1:0]         bufs;
  logic [NB_W-1:0]              n_bufs;
  logic [NB_W-1:0]              idx;
  logic [SUM_W-1:0]             total;
  logic                         done;
  logic                         bad;
  logic                         fill_en;
  logic                         judge;   // verdict cycle, seen by checker
  tbuf_t                        cur;

  tfdp_collect #(.DESC_DWORDS(DESC_DWORDS), .KEEP(KEEP)) u_collect (
    .clk(clk), .rst_n(rst_n), .en(fill_en), .in_valid(in_valid),
    .in_data(in_data), .desc_q(desc_q), .done(done)
  );

  tfdp_rules #(.MAX_BUFS(MAX_BUFS), .MAX_BUF_LEN(MAX_BUF_LEN),
               .MAX_FRAME(MAX_FRAME), .KEEP(KEEP), .SUM_W(SUM_W)) u_rules (
    .desc(desc_q), .bufs(bufs), .n_bufs(n_bufs), .pad(frm_pad),
    .total(total), .bad(bad)
  );

  tfdp_emit u_emit (
    .clk(clk), .rst_n(rst_n), .done(done), .bad(bad), .n_bufs(n_bufs),
    .rec_ready(rec_ready), .fill_en(fill_en), .judge(judge),
    .rec_valid(rec_valid), .idx(idx), .last(rec_last)
  );

  assign cur      = (int'(idx) < MAX_BUFS) ? bufs[idx] : '0;
  assign rec_addr = cur.addr;
  assign rec_len  = cur.len;
  assign frm_len  = FRM_W'(total);
  assign in_ready = fill_en;
  assign desc_err = judge && bad;
endmodule

// File: rtl/tfdp_chk.sv
module tfdp_chk #(
  parameter int MAX_BUF_LEN = 4092,
  parameter int MAX_FRAME   = 8192,
  parameter int FRM_W       = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [35:0]      rec_addr,
  input logic [11:0]      rec_len,
  input logic             rec_last,
  input logic [FRM_W-1:0] frm_len,
  input logic             desc_err,
  input logic             judge
);
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> !rec_valid);  // R4
  AST_REJECT_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |=> (in_ready && !rec_valid));  // R4
  AST_REC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_addr[1:0] == 2'b00));  // R5
  AST_REC_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_len <= 12'(MAX_BUF_LEN)));  // R6
  AST_FRAME_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (frm_len <= FRM_W'(MAX_FRAME)));  // R7
  AST_FLOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && rec_valid));  // R8
  AST_JUDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    judge |=> !judge);  // R8
  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=>
      (rec_valid && $stable(rec_addr) && $stable(rec_len) && $stable(rec_last)));  // R9
endmodule

bind tfd_parser tfdp_chk #(.MAX_BUF_LEN(MAX_BUF_LEN), .MAX_FRAME(MAX_FRAME),
                           .FRM_W(FRM_W)) u_chk (.*);

// File: tb/sim_tfd_parser.sv
`timescale 1ns/1ps
module sim_tfd_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        rec_valid;
  logic        rec_ready = 1'b0;
  logic [35:0] rec_addr;
  logic [11:0] rec_len;
  logic        rec_last;
  logic [13:0] frm_len;
  logic [1:0]  frm_pad;
  logic        desc_err;

  always #5 clk = ~clk;

  tfd_parser u0 (.*);

  int checks = 0;
  int errors = 0;
  int vprob = 100;
  int rprob = 100;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          model_on = 0;
  int          mstate = 0;   // 0 collect, 1 verdict, 2 send
  int          mcnt = 0;
  int          midx = 0;
  logic [31:0] mdesc [32];
  longint      eaddr [20];
  int          elen [20];
  int          en, etot, epad;
  bit          ebad;
  string       ewhy;
  bit          hold_prev = 0;
  logic [35:0] p_addr;
  logic [11:0] p_len;
  logic        p_last;

  task automatic judge_model();
    en   = int'(mdesc[0][28:24]);
    epad = int'(mdesc[0][31:30]);
    etot = 0; ebad = 0; ewhy = "R7";
    if (en == 0 || en > 20) begin
      ebad = 1; ewhy = "R4";
    end else begin
      for (int k = 0; k < en; k++) begin
        int p = k / 2;
        logic [35:0] a;
        int l;
        if (k % 2 == 0) begin
          a = {mdesc[2+3*p][3:0], mdesc[1+3*p]};
          l = int'(mdesc[2+3*p][15:4]);
        end else begin
          a = {mdesc[3+3*p][19:0], mdesc[2+3*p][31:16]};
          l = int'(mdesc[3+3*p][31:20]);
        end
        eaddr[k] = longint'(a);
        elen[k]  = l;
        etot += l;
        if (!ebad && a[1:0] != 0) begin ebad = 1; ewhy = "R5"; end
        if (!ebad && l > 4092)    begin ebad = 1; ewhy = "R6"; end
      end
      if (!ebad && etot > 8192) begin ebad = 1; ewhy = "R7"; end
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk(in_ready === (mstate == 0), "R8", "in_ready", in_ready, mstate == 0);
      chk(desc_err === (mstate == 1 && ebad), (mstate == 1) ? ewhy : "R8",
          "desc_err", desc_err, mstate == 1 && ebad);
      chk(rec_valid === (mstate == 2), (mstate == 1) ? "R4" : "R8",
          "rec_valid", rec_valid, mstate == 2);
      if (mstate == 2 && rec_valid === 1'b1) begin
        chk(longint'(rec_addr) == eaddr[midx], "R2", "rec_addr", rec_addr, eaddr[midx]);
        chk(int'(rec_len) == elen[midx], "R2", "rec_len", rec_len, elen[midx]);
        chk(rec_last === (midx == en - 1), "R3", "rec_last", rec_last, midx == en - 1);
        chk(int'(frm_len) == etot, "R7", "frm_len", frm_len, etot);
        chk(int'(frm_pad) == epad, "R1", "frm_pad", frm_pad, epad);
      end
      if (hold_prev) begin
        chk(rec_addr === p_addr && rec_len === p_len && rec_last === p_last,
            "R9", "held record", rec_addr, p_addr);
      end
      hold_prev = (rec_valid === 1'b1) && !rec_ready;
      p_addr = rec_addr; p_len = rec_len; p_last = rec_last;
      case (mstate)
        0: if (in_valid) begin
          mdesc[mcnt] = in_data;
          if (mcnt == 31) begin
            mcnt = 0; mstate = 1; judge_model();
          end else mcnt++;
        end
        1: begin
          mstate = ebad ? 0 : 2;
          midx = 0;
        end
        default: if (rec_ready) begin
          if (midx == en - 1) mstate = 0;
          else midx++;
        end
      endcase
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] dsc [32];

  always @(posedge clk) begin
    #1 rec_ready = ($urandom % 100) < rprob;
  end

  task automatic start(input int n, input int pad);
    for (int i = 0; i < 32; i++) dsc[i] = $urandom;
    dsc[0][28:24] = n[4:0];
    dsc[0][31:30] = pad[1:0];
  endtask

  task automatic put(input int k, input logic [35:0] a, input int l);
    int p = k / 2;
    if (k % 2 == 0) begin
      dsc[1+3*p]        = a[31:0];
      dsc[2+3*p][3:0]   = a[35:32];
      dsc[2+3*p][15:4]  = l[11:0];
    end else begin
      dsc[2+3*p][31:16] = a[15:0];
      dsc[3+3*p][19:0]  = a[35:16];
      dsc[3+3*p][31:20] = l[11:0];
    end
  endtask

  task automatic fill(input int n, input int pad, input int len);
    start(n, pad);
    for (int k = 0; k < n && k < 20; k++)
      put(k, {$urandom, 4'h0} + 36'(k * 8), len);
  endtask

  task automatic send();
    for (int i = 0; i < 32; i++) begin
      bit ok = 0;
      while (!ok) begin
        @(posedge clk); #1;
        in_valid = ($urandom % 100) < vprob;
        in_data  = in_valid ? dsc[i] : $urandom;
        #3 ok = in_valid && in_ready;
      end
    end
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #2; end while (mstate != 0);
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL R8 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready === 1'b1, "R10", "in_ready in reset", in_ready, 1);
    chk(rec_valid === 1'b0, "R10", "rec_valid in reset", rec_valid, 0);
    chk(desc_err === 1'b0, "R10", "desc_err in reset", desc_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    model_on = 1;

    // two buffers, high address bits set in both fields (R1 R2 R3)
    start(2, 1);
    put(0, 36'h9_1234_5670, 100);
    put(1, 36'h3_ABCD_0004, 4092);   // R6 boundary accepted
    send();
    // odd count, slot 3 misaligned and oversize but unused (R5)
    start(3, 3);
    put(0, 36'hF_0000_0008, 12);
    put(1, 36'h0_FFFF_FFFC, 16);
    put(2, 36'h5_5555_5554, 20);
    put(3, 36'h0_0000_0003, 4095);
    send();
    // all twenty buffers, back-pressure (R3 R9)
    rprob = 40;
    fill(20, 2, 400);
    send();
    // count rules (R4)
    rprob = 100;
    fill(0, 0, 8);   send();
    fill(21, 0, 8);  send();
    fill(31, 1, 8);  send();
    // misaligned buffer in use (R5)
    fill(4, 0, 64);  put(2, 36'h0_0000_1002, 64); send();
    // oversize buffer (R6)
    fill(2, 0, 64);  put(1, 36'h0_0000_2000, 4093); send();
    // frame total exactly at limit, then one dword over (R7)
    fill(3, 0, 4092); put(2, 36'h1_0000_0000, 8);  send();
    fill(3, 0, 4092); put(2, 36'h1_0000_0000, 12); send();
    // single buffer frame (R3)
    fill(1, 2, 0); send();

    // random traffic with gaps and stalls
    vprob = 60; rprob = 50;
    for (int t = 0; t < 40; t++) begin
      int n = 1 + int'($urandom % 20);
      fill(n, int'($urandom % 4), int'($urandom % 500));
      if ($urandom % 5 == 0) put(int'($urandom % 20), 36'($urandom) | 36'h1, 4);
      if ($urandom % 7 == 0) put(0, 36'h0_0000_0040, 4000);
      if ($urandom % 9 == 0) fill(int'($urandom % 32), 0, 4);
      send();
    end
    wait_idle();
    finish_run();
  end
endmodule